// File: doc/BRIEF.md
# Modem Status Register for a 16550-Style UART

This block holds the modem status register of a 16550-compatible UART host interface. It watches four active-low modem control pins: carrier detect, ring indicator, data set ready and clear to send. The upper nibble of the register reports the asserted level of each pin. The lower nibble holds sticky flags that record what changed since the host last read the register.

A host read of the register clears the flags. While any flag is set and the modem status interrupt enable is high, the block raises a level interrupt request. When internal loopback is on, the four status lines no longer follow the pins. They follow four bits of the modem control register instead, so software can exercise the status path without a modem attached.

Each external pin passes through a two-flop synchroniser. The sampled status is held in a register, and change detection compares the newly selected source against that register.

Top module: `uart_mdm_status`

## Requirements
- R1: After reset, `rd_data` reads 0x00 while all four pins are high (inactive), and `msr_irq` is 0.
- R2: Outside loopback, `rd_data[7]`, `[6]`, `[5]` and `[4]` report the inverted level of `dcd_n`, `ri_n`, `dsr_n` and `cts_n` respectively. A pin change shows up on `rd_data` after the third rising clock edge (two synchroniser stages plus the status register).
- R3: `rd_data[3]`, `rd_data[1]` and `rd_data[0]` are set when `rd_data[7]`, `rd_data[5]` and `rd_data[4]` respectively change in either direction. Each flag is set in the same cycle in which the new status level appears.
- R4: `rd_data[2]` is set only when the ring status bit `rd_data[6]` goes from 1 to 0. A rise of that bit leaves `rd_data[2]` unchanged.
- R5: A cycle with `rd_en`=1 and `addr`=6 clears `rd_data[3:0]` at the next edge. A read strobe with any other address, or address 6 without the strobe, leaves the flags unchanged. `rd_data` always shows the current contents, so the read returns the flags as they were before the clear.
- R6: Flags are sticky. Repeated events keep a flag at 1 until a read. An event in the same cycle as a clearing read leaves its flag set after the read.
- R7: `msr_irq` is 1 exactly when `msr_ie` is 1 and at least one of `rd_data[3:0]` is 1.
- R8: With `loop_en`=1, the status bits follow `mcr_bits` one edge after they change, with the pins ignored. The routing is `rd_data[7]`=`mcr_bits[3]`, `rd_data[6]`=`mcr_bits[2]`, `rd_data[5]`=`mcr_bits[0]` and `rd_data[4]`=`mcr_bits[1]`.
- R9: Switching `loop_en` on or off is treated like any other source change. Every status bit that differs between the old and new source raises its flag under the rules of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Host register address |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| loop_en | input | 1 | Internal loopback enable (modem control bit 4) |
| mcr_bits | input | 4 | Modem control bits: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2 |
| msr_ie | input | 1 | Modem status interrupt enable |
| dcd_n | input | 1 | Carrier detect pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| rd_data | output | 8 | Current register contents |
| msr_irq | output | 1 | Modem status interrupt request, level |

## Verification
The bench moves the pins through every ordered pair of the 16 pin patterns and computes the flags from the XOR of old and new status, with the ring flag taken from falling edges only. A design that flags a rising ring, swaps two status lanes or forgets the pin inversion fails on many of these pairs. Loopback is swept over all 16 control values, which catches a wrong routing from control bits to status bits. Further checks aim at a read that coincides with a new event, where a clear that takes priority would lose the event. Toggling loopback itself must raise flags. Reads at the wrong address, or address 6 without the strobe, must not clear anything.

// File: rtl/uart_msr_pkg.sv
// Package: shared lane indices and loopback routing for the modem status logic.
// Assumes four status lanes, ordered so that each lane index is the flag bit
// that reports it and lane+4 is its level bit.
package uart_msr_pkg;

    localparam int MSR_LANES = 4;

    // Lane positions inside a status nibble
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // Modem control bit positions
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;

    typedef logic [MSR_LANES-1:0] lane_vec_t;

    // Map modem control outputs onto status lanes for loopback
    function automatic lane_vec_t loop_route(input lane_vec_t mc);
        lane_vec_t r;
        r[LN_DCD] = mc[MC_OUT2];
        r[LN_RI]  = mc[MC_OUT1];
        r[LN_DSR] = mc[MC_DTR];
        r[LN_CTS] = mc[MC_RTS];
        return r;
    endfunction

endpackage

// File: rtl/msr_sync.sv
// Module: msr_sync
// Multi-bit flop-chain synchroniser, one independent chain per bit.
// Assumes each bit is an unrelated asynchronous level; no bus coherence.
module msr_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift the raw pin level through the stage chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[b] <= {STAGES{RST_VAL}};
            end else if (STAGES == 1) begin
                chain[b] <= async_in[b];
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/msr_src_sel.sv
// Module: msr_src_sel
// Selects the live status source: inverted synchronised pins normally,
// routed modem control bits in loopback. Purely combinational.
// Assumes pins are active low and control bits are active high.
module msr_src_sel
    import uart_msr_pkg::*;
(
    input  lane_vec_t pins_sync_n,
    input  lane_vec_t mcr_bits,
    input  logic      loop_en,
    output lane_vec_t src
);

    lane_vec_t pin_lvl;
    lane_vec_t mc_lvl;

    // Convert active-low pins to asserted levels and route control bits
    always_comb begin
        pin_lvl = ~pins_sync_n;
        mc_lvl  = loop_route(mcr_bits);
        src     = loop_en ? mc_lvl : pin_lvl;
    end

endmodule

// File: rtl/msr_flags.sv
// Module: msr_flags
// Holds the sampled status levels and the sticky change flags.
// Assumes lane LN_RI flags only a falling level; every other lane flags
// both directions. A clear and a new event in one cycle keep the event.
module msr_flags
    import uart_msr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lane_vec_t src,
    input  logic      clr,
    output lane_vec_t level_q,
    output lane_vec_t flag_q
);

    lane_vec_t evt;

    // Per-lane event detection against the previous sample
    always_comb begin
        for (int i = 0; i < MSR_LANES; i++) begin
            if (i == LN_RI) evt[i] = level_q[i] & ~src[i];
            else            evt[i] = level_q[i] ^ src[i];
        end
    end

    // Register the sampled level every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= src;
    end

    // Accumulate events, clearing on a host read without losing new ones
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (clr ? '0 : flag_q) | evt;
    end

endmodule

// File: rtl/uart_mdm_status.sv
// Module: uart_mdm_status
// Modem status register of a 16550-style UART: pin synchronisation, loopback
// source selection, sticky change flags cleared by a read, and a level IRQ.
// Assumes rd_en pulses for one cycle per host read.
module uart_mdm_status
    import uart_msr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int MSR_ADDR = 6,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              loop_en,
    input  logic [3:0]        mcr_bits,
    input  logic              msr_ie,
    input  logic              dcd_n,
    input  logic              ri_n,
    input  logic              dsr_n,
    input  logic              cts_n,
    output logic [7:0]        rd_data,
    output logic              msr_irq
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(MSR_ADDR);

    lane_vec_t pins_raw_n;
    lane_vec_t pins_sync_n;
    lane_vec_t src;
    lane_vec_t level_q;
    lane_vec_t flag_q;
    logic      clr;

    // Gather pins into lane order
    always_comb begin
        pins_raw_n         = '1;
        pins_raw_n[LN_DCD] = dcd_n;
        pins_raw_n[LN_RI]  = ri_n;
        pins_raw_n[LN_DSR] = dsr_n;
        pins_raw_n[LN_CTS] = cts_n;
    end

    msr_sync #(
        .WIDTH  (MSR_LANES),
        .STAGES (SYNC_N),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_raw_n),
        .sync_out(pins_sync_n)
    );

    msr_src_sel u_sel (
        .pins_sync_n(pins_sync_n),
        .mcr_bits   (mcr_bits),
        .loop_en    (loop_en),
        .src        (src)
    );

    // Decode a clearing host read
    always_comb clr = rd_en && (addr == SEL_ADDR);

    msr_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src),
        .clr    (clr),
        .level_q(level_q),
        .flag_q (flag_q)
    );

    // Present register contents and the interrupt level
    always_comb begin
        rd_data = {level_q, flag_q};
        msr_irq = msr_ie & (|flag_q);
    end

endmodule

// File: rtl/uart_mdm_status_chk.sv
// Module: uart_mdm_status_chk
// Port-level properties for uart_mdm_status, attached by bind below.
// Assumes it sees the same clock and reset as the block.
module uart_mdm_status_chk #(
    parameter int ADDR_W   = 3,
    parameter int MSR_ADDR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              loop_en,
    input logic [3:0]        mcr_bits,
    input logic              msr_ie,
    input logic [7:0]        rd_data,
    input logic              msr_irq
);

    logic hist_ok;
    logic clr_seen;

    // Mark when one full cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    always_comb clr_seen = rd_en && (addr == ADDR_W'(MSR_ADDR));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) && rst_n |-> rd_data[3:0] == 4'h0) else $error("reset"); // R1

    AST_DCD_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && $rose(rd_data[3]) |-> rd_data[7] != $past(rd_data[7])); // R3

    AST_TERI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && $rose(rd_data[2]) |-> $past(rd_data[6]) && !rd_data[6]); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && $past(clr_seen) && !$past(loop_en ^ loop_en)
        && rd_data[7:4] == $past(rd_data[7:4]) && rd_data[6] == $past(rd_data[6])
        |-> rd_data[3:0] == 4'h0); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && !$past(clr_seen)
        |-> (rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        msr_irq |-> msr_ie && (rd_data[3:0] != 4'h0)); // R7

    AST_IRQ_WHEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        msr_ie && (rd_data[3:0] != 4'h0) |-> msr_irq); // R7

    AST_LOOP_OUT2: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && $past(loop_en) |-> rd_data[7] == $past(mcr_bits[3])); // R8

    AST_LOOP_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && $past(loop_en) |-> rd_data[4] == $past(mcr_bits[1])); // R8

endmodule

bind uart_mdm_status uart_mdm_status_chk #(
    .ADDR_W  (ADDR_W),
    .MSR_ADDR(MSR_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .loop_en (loop_en),
    .mcr_bits(mcr_bits),
    .msr_ie  (msr_ie),
    .rd_data (rd_data),
    .msr_irq (msr_irq)
);

// File: tb/sim_uart_mdm_status.sv
// Bench for uart_mdm_status: exhaustive pin-pair sweep, loopback sweep,
// and read/event corner cases, with expected values computed locally.
module sim_uart_mdm_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       rd_en = 1'b0;
    logic       loop_en = 1'b0;
    logic [3:0] mcr_bits = 4'h0;
    logic       msr_ie = 1'b1;
    logic [3:0] pins_n = 4'hF;   // [3] dcd, [2] ri, [1] dsr, [0] cts
    logic [7:0] rd_data;
    logic       msr_irq;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_lvl = 4'h0;    // model status, lane order dcd,ri,dsr,cts
    logic [3:0] m_flg = 4'h0;

    always #2 clk = ~clk;

    uart_mdm_status u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .rd_en   (rd_en),
        .loop_en (loop_en),
        .mcr_bits(mcr_bits),
        .msr_ie  (msr_ie),
        .dcd_n   (pins_n[3]),
        .ri_n    (pins_n[2]),
        .dsr_n   (pins_n[1]),
        .cts_n   (pins_n[0]),
        .rd_data (rd_data),
        .msr_irq (msr_irq)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model a source change: update levels and flags
    task automatic model_src(input logic [3:0] nv);
        m_flg = m_flg | {m_lvl[3] ^ nv[3], m_lvl[2] & ~nv[2],
                         m_lvl[1] ^ nv[1], m_lvl[0] ^ nv[0]};
        m_lvl = nv;
    endtask

    function automatic logic [3:0] route(input logic [3:0] mc);
        return {mc[3], mc[2], mc[0], mc[1]};
    endfunction

    task automatic cmp_all(input string tag);
        chk(tag, {rd_data, msr_irq}, {m_lvl, m_flg, msr_ie & (|m_flg)});
    endtask

    // Drive pins at a falling edge and wait out the three-edge latency
    task automatic set_pins(input logic [3:0] p);
        pins_n = p;
        if (!loop_en) model_src(~p);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // One host read at address a with strobe s
    task automatic host_rd(input logic [2:0] a, input logic s);
        addr = a;
        rd_en = s;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        if (s && a == 3'd6) m_flg = 4'h0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R1 reset state");

        // R2 R3 R4 R7: every ordered pair of pin patterns
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_pins(4'(a));
                host_rd(3'd6, 1'b1);
                msr_ie = 1'((a + b) % 2);
                set_pins(4'(b));
                cmp_all("R2_R3_R4_R7 pin pair");
                msr_ie = 1'b1;
            end
        end

        // R5: non-clearing accesses keep flags
        set_pins(4'h0);
        host_rd(3'd6, 1'b1);
        set_pins(4'hF);
        host_rd(3'd5, 1'b1);
        cmp_all("R5 wrong address keeps flags");
        host_rd(3'd6, 1'b0);
        cmp_all("R5 no strobe keeps flags");
        chk("R5 read returns flags", {1'b0, rd_data}, {1'b0, m_lvl, m_flg});
        host_rd(3'd6, 1'b1);
        cmp_all("R5 read clears");

        // R6: repeated events stay set
        set_pins(4'h7);
        set_pins(4'hF);
        cmp_all("R6 flag sticky over two events");
        host_rd(3'd6, 1'b1);

        // R8: loopback sweep, pins held asserted and ignored
        set_pins(4'h0);
        host_rd(3'd6, 1'b1);
        mcr_bits = 4'hF;
        loop_en = 1'b1;
        model_src(route(4'hF));
        @(posedge clk);
        @(negedge clk);
        host_rd(3'd6, 1'b1);
        for (int k = 0; k < 16; k++) begin
            mcr_bits = 4'(k);
            model_src(route(4'(k)));
            @(posedge clk);
            @(negedge clk);
            cmp_all("R8 loopback routing");
            pins_n = ~pins_n;
            repeat (3) @(posedge clk);
            @(negedge clk);
            cmp_all("R8 pins ignored in loopback");
            host_rd(3'd6, 1'b1);
        end

        // R6: event coincident with a clearing read survives
        mcr_bits = 4'h0;
        model_src(route(4'h0));
        @(posedge clk);
        @(negedge clk);
        host_rd(3'd6, 1'b1);
        mcr_bits = 4'h8;
        addr = 3'd6;
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R6 coincident event kept", {1'b0, rd_data}, {1'b0, 4'h8, 4'h8});

        // R9: loopback toggling raises flags
        host_rd(3'd6, 1'b1);
        pins_n = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_lvl = 4'h8;
        m_flg = 4'h0;
        loop_en = 1'b0;
        model_src(4'hF);
        @(posedge clk);
        @(negedge clk);
        cmp_all("R9 loopback off flags");
        host_rd(3'd6, 1'b1);
        mcr_bits = 4'h0;
        loop_en = 1'b1;
        model_src(4'h0);
        @(posedge clk);
        @(negedge clk);
        cmp_all("R9 loopback on flags");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule